// File: doc/BRIEF.md
# Power-up reset and clock-enable sequencer

This block sits in the system controller and turns one board-level, active-low power-up reset into the staged start-up of two processors and a radio-interface logic block. After the incoming reset releases, it brings the reference clock into use. It then produces a half-rate clock enable for the control processor and a full-rate clock enable for the signal processor. Both enables run while the matching reset is still held, because both processors reset synchronously and need clock edges to do so.

The control processor leaves reset by itself after a fixed number of its own clock enables. The signal processor and the radio-interface logic leave reset only when software says so. Software writes a small control word through a single write strobe. That word also gates the 32 kHz sleep clock and enables external SRAM and EEPROM access. Each side's shared bidirectional pins stay inputs until that side is out of reset.

Top module: `rcs_seq`

## Requirements
- R1: While `por_n` is low, every output is 0: all resets asserted, both clock enables off, the sleep-clock gate off, both pin output enables off, SRAM and EEPROM access off. The control word returns to all zeros, and it reads as all zeros again after a later release.
- R2: `dsp_ce` goes high after the second rising clock edge following the release of `por_n`. It stays high on every cycle, including while the signal-processor reset is held.
- R3: `cpu_ce` is high on alternate cycles only. Its first high cycle follows the third rising edge after the release of `por_n`.
- R4: `cpu_rst_n` goes high after exactly 128 cycles in which `cpu_ce` was high. It goes high on the edge that samples the 128th such cycle.
- R5: A write presented while `cpu_rst_n` is low is ignored. This includes a write sampled on the same edge that releases `cpu_rst_n`.
- R6: An accepted write replaces the whole control word from `wr_data`. Bit 0 is the sleep-clock gate, bit 1 releases the signal processor, bit 2 is SRAM access and bit 3 is EEPROM access. The new values appear at the outputs after the sampling edge.
- R7: `dsp_rst_n` and `rfi_rst_n` stay low until an accepted write sets bit 1. A later write that clears bit 1 asserts them again.
- R8: `rfi_rst_n` and all other resets go low as soon as `por_n` falls, with no clock edge needed.
- R9: `cpu_oe` and `dsp_oe` are low while their reset is asserted. Each rises one cycle after its reset releases, and `dsp_oe` drops on the same edge that reasserts its reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Board power-up reset, active low, asynchronous |
| wr_en | input | 1 | Control-word write strobe from the control processor |
| wr_data | input | 4 | Control word: bit0 sleep gate, bit1 DSP run, bit2 SRAM, bit3 EEPROM |
| cpu_ce | output | 1 | Half-rate clock enable for the control processor |
| dsp_ce | output | 1 | Full-rate clock enable for the signal processor |
| slow_gate | output | 1 | Sleep-clock (32 kHz) gate enable |
| cpu_rst_n | output | 1 | Control-processor reset, active low |
| dsp_rst_n | output | 1 | Signal-processor reset, active low |
| rfi_rst_n | output | 1 | Radio-interface logic reset, active low |
| cpu_oe | output | 1 | Output enable of pins shared with the control processor |
| dsp_oe | output | 1 | Output enable of pins shared with the signal processor |
| sram_en | output | 1 | External SRAM access enable |
| eeprom_en | output | 1 | EEPROM access enable |

## Verification
Two functions can fall in the same cycle. The counter ends the control processor's reset on one edge, and software may present a control-word write on that very edge. The bench holds a write of all ones exactly on the releasing edge. It then expects `cpu_rst_n` to rise while the control word stays at zero on that cycle and the next. A later write must then be accepted. A second overlap is a reset-reasserting write, where `dsp_oe` must drop on the same edge as `dsp_rst_n`.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
    localparam int CTRL_W  = 4;
    localparam int CB_SLOW = 0;
    localparam int CB_DSP  = 1;
    localparam int CB_SRAM = 2;
    localparam int CB_EEP  = 3;

    typedef struct packed {
        logic eeprom_en;
        logic sram_en;
        logic dsp_run;
        logic slow_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_bits(input logic [CTRL_W-1:0] b);
        ctrl_t c;
        c.slow_en   = b[CB_SLOW];
        c.dsp_run   = b[CB_DSP];
        c.sram_en   = b[CB_SRAM];
        c.eeprom_en = b[CB_EEP];
        return c;
    endfunction
endpackage

// File: rtl/rcs_rel_sync.sv
module rcs_rel_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    output logic run
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sh[0] = 1'b1;
        for (int i = 1; i < STAGES; i++) begin
            st_d.sh[i] = st_q.sh[i-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run = st_q.sh[STAGES-1];
endmodule

// File: rtl/rcs_ce_gen.sv
module rcs_ce_gen #(
    parameter int CPU_DIV = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic run,
    output logic cpu_ce,
    output logic dsp_ce
);
    localparam int PW = (CPU_DIV > 1) ? $clog2(CPU_DIV) : 1;
    localparam logic [PW-1:0] PLAST = PW'(CPU_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] phase;
        logic          ce;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.ce = 1'b0;
        if (run) begin
            if (st_q.phase == '0) st_d.ce = 1'b1;
            st_d.phase = (st_q.phase == PLAST) ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cpu_ce = st_q.ce;
    assign dsp_ce = run;
endmodule

// File: rtl/rcs_cpu_rst.sv
module rcs_cpu_rst #(
    parameter int CNT_W       = 8,
    parameter int HOLD_CYCLES = 128
) (
    input  logic clk,
    input  logic por_n,
    input  logic ce,
    output logic rel,
    output logic oe
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             rel;
        logic             oe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.rel && ce) begin
            if (st_q.cnt == LAST) st_d.rel = 1'b1;
            else                  st_d.cnt = st_q.cnt + 1'b1;
        end
        st_d.oe = st_d.rel & st_q.rel;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rel = st_q.rel;
    assign oe  = st_q.oe;
endmodule

// File: rtl/rcs_ctrl_regs.sv
module rcs_ctrl_regs
    import rcs_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              accept,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic              dsp_oe
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  oe;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && accept) st_d.ctrl = ctrl_from_bits(wr_data);
        st_d.oe = st_d.ctrl.dsp_run & st_q.ctrl.dsp_run;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl   = st_q.ctrl;
    assign dsp_oe = st_q.oe;
endmodule

// File: rtl/rcs_seq.sv
module rcs_seq
    import rcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CPU_DIV     = 2,
    parameter int CNT_W       = 8,
    parameter int HOLD_CYCLES = 128
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic              cpu_ce,
    output logic              dsp_ce,
    output logic              slow_gate,
    output logic              cpu_rst_n,
    output logic              dsp_rst_n,
    output logic              rfi_rst_n,
    output logic              cpu_oe,
    output logic              dsp_oe,
    output logic              sram_en,
    output logic              eeprom_en
);
    logic  run;
    logic  cpu_rel;
    ctrl_t ctrl;

    rcs_rel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por_n (por_n),
        .run   (run)
    );

    rcs_ce_gen #(.CPU_DIV(CPU_DIV)) u_ce (
        .clk    (clk),
        .por_n  (por_n),
        .run    (run),
        .cpu_ce (cpu_ce),
        .dsp_ce (dsp_ce)
    );

    rcs_cpu_rst #(.CNT_W(CNT_W), .HOLD_CYCLES(HOLD_CYCLES)) u_cpu (
        .clk   (clk),
        .por_n (por_n),
        .ce    (cpu_ce),
        .rel   (cpu_rel),
        .oe    (cpu_oe)
    );

    rcs_ctrl_regs u_regs (
        .clk     (clk),
        .por_n   (por_n),
        .accept  (cpu_rel),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .dsp_oe  (dsp_oe)
    );

    assign cpu_rst_n = cpu_rel;
    assign dsp_rst_n = ctrl.dsp_run;
    assign rfi_rst_n = por_n & ctrl.dsp_run;
    assign slow_gate = ctrl.slow_en;
    assign sram_en   = ctrl.sram_en;
    assign eeprom_en = ctrl.eeprom_en;
endmodule

// File: rtl/rcs_seq_chk.sv
module rcs_seq_chk (
    input logic clk,
    input logic por_n,
    input logic wr_en,
    input logic cpu_ce,
    input logic dsp_ce,
    input logic slow_gate,
    input logic cpu_rst_n,
    input logic dsp_rst_n,
    input logic rfi_rst_n,
    input logic cpu_oe,
    input logic dsp_oe
);
    always @(posedge clk) begin
        if (por_n === 1'b0)
            AST_POR_ALL_RESET: assert (!cpu_rst_n && !dsp_rst_n && !rfi_rst_n && !cpu_ce && !dsp_ce); // R1
    end

    AST_SLEEP_GATE_BY_WRITE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(slow_gate) |-> $past(wr_en)); // R6

    AST_DSP_CE_COVERS_CPU: assert property (@(posedge clk) disable iff (!por_n)
        cpu_ce |-> dsp_ce); // R2

    AST_CPU_CE_ALTERNATES: assert property (@(posedge clk) disable iff (!por_n)
        cpu_ce |=> !cpu_ce); // R3

    AST_CPU_RELEASE_ON_CE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(cpu_rst_n) |-> $past(cpu_ce)); // R4

    AST_DSP_HELD_BEHIND_CPU: assert property (@(posedge clk) disable iff (!por_n)
        !cpu_rst_n |-> (!dsp_rst_n && !rfi_rst_n)); // R7

    AST_CPU_PINS_INPUT: assert property (@(posedge clk) disable iff (!por_n)
        !cpu_rst_n |-> !cpu_oe); // R9

    AST_DSP_PINS_INPUT: assert property (@(posedge clk) disable iff (!por_n)
        !dsp_rst_n |-> !dsp_oe); // R9
endmodule

bind rcs_seq rcs_seq_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .wr_en     (wr_en),
    .cpu_ce    (cpu_ce),
    .dsp_ce    (dsp_ce),
    .slow_gate (slow_gate),
    .cpu_rst_n (cpu_rst_n),
    .dsp_rst_n (dsp_rst_n),
    .rfi_rst_n (rfi_rst_n),
    .cpu_oe    (cpu_oe),
    .dsp_oe    (dsp_oe)
);

// File: tb/rcs_seq_tb.sv
`timescale 1ns/100ps
module rcs_seq_tb;
    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = 4'h0;
    logic cpu_ce, dsp_ce, slow_gate, cpu_rst_n, dsp_rst_n, rfi_rst_n;
    logic cpu_oe, dsp_oe, sram_en, eeprom_en;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int pulses = 0;
    logic prev_rst_n = 1'b0;
    bit done = 0;

    // obs bits: 9 cpu_ce, 8 dsp_ce, 7 slow, 6 cpu_rst_n, 5 dsp_rst_n,
    //           4 rfi_rst_n, 3 cpu_oe, 2 dsp_oe, 1 sram, 0 eeprom
    logic [9:0] obs;
    assign obs = {cpu_ce, dsp_ce, slow_gate, cpu_rst_n, dsp_rst_n,
                  rfi_rst_n, cpu_oe, dsp_oe, sram_en, eeprom_en};

    typedef struct {
        int         at;
        logic [9:0] mask;
        logic [9:0] val;
        string      req;
    } item_t;
    item_t q[$];

    rcs_seq u_dut (
        .clk(clk), .por_n(por_n), .wr_en(wr_en), .wr_data(wr_data),
        .cpu_ce(cpu_ce), .dsp_ce(dsp_ce), .slow_gate(slow_gate),
        .cpu_rst_n(cpu_rst_n), .dsp_rst_n(dsp_rst_n), .rfi_rst_n(rfi_rst_n),
        .cpu_oe(cpu_oe), .dsp_oe(dsp_oe), .sram_en(sram_en), .eeprom_en(eeprom_en)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic expect_at(input int at, input logic [9:0] mask, input logic [9:0] val, input string req);
        item_t it;
        it.at = at; it.mask = mask; it.val = val; it.req = req;
        q.push_back(it);
    endtask

    task automatic goto(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = 4'h0;
    endtask

    // monitor: pops expected items and counts processor clock enables in reset
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            item_t it;
            it = q.pop_front();
            chk(it.at == cyc && (obs & it.mask) == (it.val & it.mask), it.req,
                obs & it.mask, it.val & it.mask);
        end
        if (por_n && cpu_ce && !cpu_rst_n) pulses++;
        if (por_n && !prev_rst_n && cpu_rst_n) begin
            // R4: exactly 128 enable cycles before release
            chk(pulses == 128, "R4", 10'(pulses), 10'd128);
        end
        if (!por_n) pulses = 0;
        prev_rst_n = cpu_rst_n;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog R4: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int n;
        int m;
        repeat (3) @(negedge clk);
        chk(obs == 10'b0, "R1", obs, 10'b0);

        // first release
        n = cyc;
        por_n = 1'b1;
        expect_at(n+1, 10'h3FF, 10'b0000000000, "R2");
        expect_at(n+2, 10'b1100000000, 10'b0100000000, "R2");
        expect_at(n+3, 10'b1100000000, 10'b1100000000, "R3");
        expect_at(n+4, 10'b1100000000, 10'b0100000000, "R3");
        expect_at(n+5, 10'b1100000000, 10'b1100000000, "R3");
        // R5: write during processor reset ignored
        expect_at(n+101, 10'b0010110111, 10'b0, "R5");
        expect_at(n+102, 10'b0010110111, 10'b0, "R5");
        expect_at(n+150, 10'b0100100000, 10'b0100000000, "R2");
        expect_at(n+257, 10'b1001000000, 10'b1000000000, "R4");
        // R5: write on the releasing edge ignored
        expect_at(n+258, 10'b1011111111, 10'b0001000000, "R5");
        expect_at(n+259, 10'b0011111111, 10'b0001001000, "R9");
        expect_at(n+263, 10'b0010110111, 10'b0010000000, "R6");
        expect_at(n+264, 10'b0000000100, 10'b0, "R9");
        expect_at(n+267, 10'b0000110100, 10'b0000110000, "R7");
        expect_at(n+268, 10'b0000000100, 10'b0000000100, "R9");
        expect_at(n+271, 10'b0010110111, 10'b0010110111, "R6");
        expect_at(n+275, 10'b0010110111, 10'b0010000010, "R7");

        goto(n+100); wr(4'hF);
        goto(n+257); wr(4'hF);
        goto(n+262); wr(4'b0001);
        goto(n+266); wr(4'b0011);
        goto(n+270); wr(4'b1111);
        goto(n+274); wr(4'b0101);
        goto(n+280);

        // asynchronous assertion of power-up reset
        @(posedge clk);
        #0.5 por_n = 1'b0;
        #1;
        chk(rfi_rst_n == 1'b0, "R8", {9'b0, rfi_rst_n}, 10'b0);
        chk(obs == 10'b0, "R1", obs, 10'b0);
        repeat (3) @(negedge clk);
        chk(obs == 10'b0, "R1", obs, 10'b0);

        // second release: defaults return
        m = cyc;
        por_n = 1'b1;
        expect_at(m+257, 10'b0001000000, 10'b0, "R4");
        expect_at(m+258, 10'b0011110111, 10'b0001000000, "R1");
        goto(m+262);

        while (q.size() > 0) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule